// File: doc/BRIEF.md
# Three-Phase Gate Drive with Dead-Time Insertion

This block sits between a PWM engine and the gate drivers of a three-phase inverter bridge. Each phase has one command bit. The block turns it into a complementary pair of gate signals, one for the high-side switch and one for the low-side switch. When a command bit changes, the switch that was conducting is released at once. Its partner is held off for a programmable guard interval, so both switches of a leg never conduct together. The guard interval is counted at the full clock rate or at half of it. Counting starts either on the command transition itself or on the falling edge of a per-phase timer pulse.

A single configuration word holds the guard length, the counting rate, the gate polarity, a guard bypass and the start-event choice. The word accepts writes only while a separate unlock bit is set. A global output enable forces every gate to its inactive level and abandons any guard in progress. The block also tracks whether the carrier underflow strobe has fired an odd or an even number of times. It reports this parity only when the carrier is triangular and the extended timer set is active.

Top module: `gate_deadband_stage`

## Requirements
- R1: After reset the configuration word is all zero (guard length 0, full rate, active-low gates, guard enabled, timer-pulse start), the unlock bit is 0 and the parity flag is 0. With out_en low, all six gate pins read 1.
- R2: Bit 9 of the configuration word (act_high) sets gate polarity: 1 makes an asserted gate read 1, and 0 makes an asserted gate read 0.
- R3: When bit 10 (bypass) is 1, or the guard length in bits 7:0 is 0, each gate pair follows its command bit one clock after the bit is sampled: the high side is asserted for command 1, the low side for command 0.
- R4: When bit 8 (half_rate) is 0 and bit 11 (start) is 1, a command change of a phase sampled at edge e0 deasserts both gates of that phase from e0. The new side is asserted from edge e0+N, where N is the guard length.
- R5: When half_rate is 1, the same window lasts 2N clocks: the new side is asserted from edge e0+2N.
- R6: When start is 0, the guard count begins only at the edge (ef) at which that phase's timer pulse input is seen falling. Both gates stay deasserted until then, and the new side is asserted from edge ef+N.
- R7: The two gates of a phase are never asserted together. Outside the guard window, with out_en high, exactly one of them is asserted.
- R8: A further command change during the guard window restarts the full window from that change. If the command returns to its earlier value, the side that was pending is never asserted.
- R9: While out_en is low, all six gates are deasserted and every guard window is abandoned. When out_en rises again, the gates follow the current commands with no guard.
- R10: A configuration write is accepted only while the unlock bit, set by wp_wr with value wp_val, is 1. Otherwise the write has no effect.
- R11: The internal parity toggles on every carrier_uf strobe. parity_odd shows it only when carrier_tri and ext_timers are both 1, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_wr | input | 1 | Strobe that loads the unlock bit |
| wp_val | input | 1 | Value loaded into the unlock bit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | DT_W+4 | Configuration word: [7:0] guard length, [8] half_rate, [9] act_high, [10] bypass, [11] start |
| out_en | input | 1 | Global gate enable |
| phase_cmd | input | PHASES | Per-phase command bit (1 = high side) |
| oneshot | input | PHASES | Per-phase timer pulse; its falling edge starts the guard when start = 0 |
| carrier_uf | input | 1 | Carrier underflow strobe |
| carrier_tri | input | 1 | High when the carrier is triangular |
| ext_timers | input | 1 | High when the extended timer set is in use |
| gate_hi | output | PHASES | High-side gate pins |
| gate_lo | output | PHASES | Low-side gate pins |
| parity_odd | output | 1 | Odd-underflow flag, gated by carrier_tri and ext_timers |

## Verification
The bench builds the block with its defaults: three phases and an 8-bit guard length. It programs short lengths of 2 and 3, so every window edge of R4, R5, R6 and R8 can be sampled clock by clock. It also uses length 0 and a nonzero length under bypass, which shows that both give the same immediate behaviour. Because there are three phases, one phase can be exercised while the other two are checked to remain steady.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    // Per-phase sequencer state
    typedef enum logic [1:0] {
        PH_STEADY = 2'd0,   // one side asserted, following the settled level
        PH_WAIT   = 2'd1,   // both sides off, waiting for the start event
        PH_COUNT  = 2'd2    // both sides off, guard counter running
    } ph_state_e;

    // Start-event choice carried in the configuration word
    typedef enum logic {
        START_PULSE_FALL = 1'b0,
        START_CMD_EDGE   = 1'b1
    } start_sel_e;

endpackage

// File: rtl/gdb_ctrl.sv
module gdb_ctrl #(
    parameter int DT_W = 8,
    localparam int CFG_W = DT_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_wr,
    input  logic             wp_val,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             carrier_uf,
    input  logic             carrier_tri,
    input  logic             ext_timers,
    output logic [DT_W-1:0]  dt_len,
    output logic             half_rate,
    output logic             act_high,
    output logic             bypass,
    output logic             start_cmd,
    output logic             unlock,
    output logic [CFG_W-1:0] cfg_word,
    output logic             par_raw,
    output logic             parity_odd
);

    typedef struct packed {
        logic            start;
        logic            bypass;
        logic            act_high;
        logic            half_rate;
        logic [DT_W-1:0] len;
    } cfg_t;

    typedef struct packed {
        logic unlock;
        cfg_t cfg;
        logic par;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wp_wr) begin
            st_d.unlock = wp_val;
        end
        if (cfg_wr && st_q.unlock) begin
            st_d.cfg = cfg_t'(cfg_wdata);
        end
        if (carrier_uf) begin
            st_d.par = ~st_q.par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dt_len     = st_q.cfg.len;
    assign half_rate  = st_q.cfg.half_rate;
    assign act_high   = st_q.cfg.act_high;
    assign bypass     = st_q.cfg.bypass;
    assign start_cmd  = (st_q.cfg.start == gdb_pkg::START_CMD_EDGE);
    assign unlock     = st_q.unlock;
    assign cfg_word   = st_q.cfg;
    assign par_raw    = st_q.par;
    assign parity_odd = st_q.par & carrier_tri & ext_timers;

endmodule

// File: rtl/gdb_phase.sv
module gdb_phase
    import gdb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cmd,
    input  logic            pulse,
    input  logic [DT_W-1:0] dt_len,
    input  logic            half_rate,
    input  logic            bypass,
    input  logic            start_cmd,
    output logic            hi_on,
    output logic            lo_on
);

    typedef struct packed {
        ph_state_e       st;
        logic            lvl;      // settled level driving the gates
        logic            tgt;      // last sampled command
        logic [DT_W-1:0] cnt;
        logic            half_ph;  // divider phase for half-rate counting
        logic            pulse_q;  // previous timer pulse level
    } ph_t;

    ph_t  ph_d, ph_q;
    logic no_guard;
    logic changed;
    logic pulse_fall;
    logic tick;

    always_comb begin
        no_guard   = bypass || (dt_len == '0);
        changed    = (cmd != ph_q.tgt);
        pulse_fall = ph_q.pulse_q && !pulse;
        tick       = !half_rate || ph_q.half_ph;

        ph_d         = ph_q;
        ph_d.pulse_q = pulse;

        if (!en || no_guard) begin
            ph_d.st      = PH_STEADY;
            ph_d.lvl     = cmd;
            ph_d.tgt     = cmd;
            ph_d.cnt     = '0;
            ph_d.half_ph = 1'b0;
        end else if (changed) begin
            ph_d.tgt     = cmd;
            ph_d.cnt     = dt_len;
            ph_d.half_ph = 1'b0;
            ph_d.st      = start_cmd ? PH_COUNT : PH_WAIT;
        end else begin
            unique case (ph_q.st)
                PH_WAIT: begin
                    if (pulse_fall) begin
                        ph_d.st      = PH_COUNT;
                        ph_d.half_ph = 1'b0;
                    end
                end
                PH_COUNT: begin
                    ph_d.half_ph = ~ph_q.half_ph;
                    if (tick) begin
                        if (ph_q.cnt <= DT_W'(1)) begin
                            ph_d.st  = PH_STEADY;
                            ph_d.lvl = ph_q.tgt;
                            ph_d.cnt = '0;
                        end else begin
                            ph_d.cnt = ph_q.cnt - DT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{st: PH_STEADY, lvl: 1'b0, tgt: 1'b0, cnt: '0,
                      half_ph: 1'b0, pulse_q: 1'b0};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign hi_on = (ph_q.st == PH_STEADY) &&  ph_q.lvl;
    assign lo_on = (ph_q.st == PH_STEADY) && !ph_q.lvl;

endmodule

// File: rtl/gate_deadband_stage.sv
module gate_deadband_stage #(
    parameter int PHASES = 3,
    parameter int DT_W   = 8,
    localparam int CFG_W = DT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_wr,
    input  logic              wp_val,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              out_en,
    input  logic [PHASES-1:0] phase_cmd,
    input  logic [PHASES-1:0] oneshot,
    input  logic              carrier_uf,
    input  logic              carrier_tri,
    input  logic              ext_timers,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              parity_odd
);

    logic [DT_W-1:0]   cfg_len;
    logic              cfg_half;
    logic              cfg_act_high;
    logic              cfg_bypass;
    logic              cfg_start_cmd;
    logic              cfg_unlock;
    logic [CFG_W-1:0]  cfg_word;
    logic              par_raw;
    logic [PHASES-1:0] hi_on;
    logic [PHASES-1:0] lo_on;

    gdb_ctrl #(.DT_W(DT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_wr      (wp_wr),
        .wp_val     (wp_val),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .carrier_uf (carrier_uf),
        .carrier_tri(carrier_tri),
        .ext_timers (ext_timers),
        .dt_len     (cfg_len),
        .half_rate  (cfg_half),
        .act_high   (cfg_act_high),
        .bypass     (cfg_bypass),
        .start_cmd  (cfg_start_cmd),
        .unlock     (cfg_unlock),
        .cfg_word   (cfg_word),
        .par_raw    (par_raw),
        .parity_odd (parity_odd)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        gdb_phase #(.DT_W(DT_W)) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (out_en),
            .cmd      (phase_cmd[p]),
            .pulse    (oneshot[p]),
            .dt_len   (cfg_len),
            .half_rate(cfg_half),
            .bypass   (cfg_bypass),
            .start_cmd(cfg_start_cmd),
            .hi_on    (hi_on[p]),
            .lo_on    (lo_on[p])
        );

        // Polarity stage: an asserted gate reads act_high
        always_comb begin
            gate_hi[p] = (out_en && hi_on[p]) ? cfg_act_high : ~cfg_act_high;
            gate_lo[p] = (out_en && lo_on[p]) ? cfg_act_high : ~cfg_act_high;
        end
    end

endmodule

// File: rtl/gdb_checker.sv
module gdb_checker #(
    parameter int PHASES = 3,
    parameter int DT_W   = 8,
    localparam int CFG_W = DT_W + 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_en,
    input logic              cfg_wr,
    input logic [PHASES-1:0] phase_cmd,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo,
    input logic              act_high,
    input logic              bypass,
    input logic              unlock,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              par_raw,
    input logic              carrier_uf
);

    logic [PHASES-1:0] hi_act;
    logic [PHASES-1:0] lo_act;

    assign hi_act = act_high ? gate_hi : ~gate_hi;
    assign lo_act = act_high ? gate_lo : ~gate_lo;

    a_r7_arms_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_act & lo_act) == '0);

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (hi_act == '0 && lo_act == '0));

    a_r10_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !unlock) |=> $stable(cfg_word));

    a_r11_parity_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_uf |=> (par_raw != $past(par_raw)));

    a_r11_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_uf |=> $stable(par_raw));

    a_r3_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && out_en && !cfg_wr) |=>
        (!out_en || (hi_act == $past(phase_cmd) && lo_act == ~$past(phase_cmd))));

endmodule

bind gate_deadband_stage gdb_checker #(.PHASES(PHASES), .DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .cfg_wr    (cfg_wr),
    .phase_cmd (phase_cmd),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .act_high  (cfg_act_high),
    .bypass    (cfg_bypass),
    .unlock    (cfg_unlock),
    .cfg_word  (cfg_word),
    .par_raw   (par_raw),
    .carrier_uf(carrier_uf)
);

// File: tb/gate_deadband_stage_test.sv
module gate_deadband_stage_test;

    localparam int PHASES = 3;
    localparam int DT_W   = 8;
    localparam int CFG_W  = DT_W + 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wp_wr, wp_val, cfg_wr;
    logic [CFG_W-1:0]  cfg_wdata;
    logic              out_en;
    logic [PHASES-1:0] phase_cmd, oneshot;
    logic              carrier_uf, carrier_tri, ext_timers;
    logic [PHASES-1:0] gate_hi, gate_lo;
    logic              parity_odd;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gate_deadband_stage #(.PHASES(PHASES), .DT_W(DT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wp_wr(wp_wr), .wp_val(wp_val),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .out_en(out_en),
        .phase_cmd(phase_cmd), .oneshot(oneshot), .carrier_uf(carrier_uf),
        .carrier_tri(carrier_tri), .ext_timers(ext_timers),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .parity_odd(parity_odd)
    );

    // Table entry: [10] act_high, [9] bypass, [8:6] cmd, [5:3] gate_hi, [2:0] gate_lo
    localparam logic [10:0] VEC [6] = '{
        {1'b0, 1'b0, 3'b101, 3'b010, 3'b101},
        {1'b1, 1'b0, 3'b101, 3'b101, 3'b010},
        {1'b1, 1'b1, 3'b011, 3'b011, 3'b100},
        {1'b0, 1'b1, 3'b110, 3'b001, 3'b110},
        {1'b1, 1'b1, 3'b000, 3'b000, 3'b111},
        {1'b0, 1'b0, 3'b111, 3'b000, 3'b111}
    };

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic write_cfg(input logic start, input logic byp, input logic act,
                             input logic half, input logic [DT_W-1:0] len);
        cfg_wdata = {start, byp, act, half, len};
        cfg_wr    = 1'b1;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic set_lock(input logic v);
        wp_wr  = 1'b1;
        wp_val = v;
        step();
        wp_wr  = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wp_wr = 1'b0; wp_val = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
        out_en = 1'b0; phase_cmd = '0; oneshot = '0;
        carrier_uf = 1'b0; carrier_tri = 1'b1; ext_timers = 1'b1;
        step(3);
        // R1: reset state, active-low and disabled -> all pins 1
        check("R1 gate_hi at reset", 32'(gate_hi), 32'h7);
        check("R1 gate_lo at reset", 32'(gate_lo), 32'h7);
        check("R1 parity at reset", 32'(parity_odd), 32'h0);
        rst_n = 1'b1;
        step();
        out_en = 1'b1;
        set_lock(1'b1);

        // Table: polarity (R2) and no-guard following (R3)
        foreach (VEC[k]) begin
            phase_cmd = VEC[k][8:6];
            write_cfg(1'b1, VEC[k][9], VEC[k][10], 1'b0, VEC[k][9] ? 8'd5 : 8'd0);
            step();
            check($sformatf("R2/R3 vec%0d gate_hi", k), 32'(gate_hi), 32'(VEC[k][5:3]));
            check($sformatf("R2/R3 vec%0d gate_lo", k), 32'(gate_lo), 32'(VEC[k][2:0]));
        end

        // R4: full rate, start on command edge, N=3; cmd now 111, active high
        write_cfg(1'b1, 1'b0, 1'b1, 1'b0, 8'd3);
        phase_cmd = 3'b110;
        step();
        check("R4 both off after e0", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        step(2);
        check("R4 both off after e2", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        check("R7 other phases steady", 32'(gate_hi[2:1]), 32'h3);
        step();
        check("R4 low side on after e3 hi", 32'(gate_hi), 32'h6);
        check("R4 low side on after e3 lo", 32'(gate_lo), 32'h1);

        // R5: half rate, N=2 -> 4 clocks
        write_cfg(1'b1, 1'b0, 1'b1, 1'b1, 8'd2);
        phase_cmd = 3'b111;
        step();
        check("R5 both off after e0", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        step(3);
        check("R5 both off after e3", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        step();
        check("R5 high side on after e4", {30'd0, gate_hi[0], gate_lo[0]}, 32'h2);

        // R6: start on timer pulse falling edge, N=2 full rate
        oneshot = 3'b111;
        write_cfg(1'b0, 1'b0, 1'b1, 1'b0, 8'd2);
        phase_cmd = 3'b110;
        step(5);
        check("R6 waiting for pulse edge", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        oneshot[0] = 1'b0;
        step(2);
        check("R6 still off at ef+1", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        step();
        check("R6 low side on at ef+2", {30'd0, gate_hi[0], gate_lo[0]}, 32'h1);

        // R8: restart mid-window, pending high side never asserted
        write_cfg(1'b1, 1'b0, 1'b1, 1'b0, 8'd3);
        phase_cmd = 3'b111;
        step();
        phase_cmd = 3'b110;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R8 pending side stays off", {30'd0, gate_hi[0], gate_lo[0]}, 32'h0);
        end
        step();
        check("R8 earlier side back after restart", {30'd0, gate_hi[0], gate_lo[0]}, 32'h1);

        // R9: disable abandons the window
        phase_cmd = 3'b111;
        step();
        out_en = 1'b0;
        step();
        check("R9 gate_hi inactive", 32'(gate_hi), 32'h0);
        check("R9 gate_lo inactive", 32'(gate_lo), 32'h0);
        step();
        out_en = 1'b1;
        #1;
        check("R9 no guard after enable", 32'(gate_hi), 32'h7);
        step();

        // R10: locked writes ignored
        set_lock(1'b0);
        write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'd3);
        step();
        check("R10 locked write ignored", 32'(gate_hi), 32'h7);
        set_lock(1'b1);
        write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'd3);
        step();
        check("R10 unlocked write taken hi", 32'(gate_hi), 32'h0);
        check("R10 unlocked write taken lo", 32'(gate_lo), 32'h7);

        // R11: parity
        for (int i = 0; i < 3; i++) begin
            carrier_uf = 1'b1;
            step();
            carrier_uf = 1'b0;
            check("R11 parity after strobe", 32'(parity_odd), (i % 2 == 0) ? 32'h1 : 32'h0);
        end
        carrier_tri = 1'b0;
        #1;
        check("R11 hidden without triangular carrier", 32'(parity_odd), 32'h0);
        carrier_tri = 1'b1;
        ext_timers  = 1'b0;
        #1;
        check("R11 hidden without extended timers", 32'(parity_odd), 32'h0);
        ext_timers = 1'b1;
        #1;
        check("R11 visible again", 32'(parity_odd), 32'h1);

        // R1: reset clears parity and configuration
        step();
        out_en = 1'b0;
        rst_n  = 1'b0;
        step();
        check("R1 parity cleared by reset", 32'(parity_odd), 32'h0);
        check("R1 polarity back to active low", 32'(gate_hi), 32'h7);
        rst_n = 1'b1;
        step();

        finish_run();
    end

endmodule